// File: doc/BRIEF.md
# Banked and Relative Branch Target Unit

This block computes the next program counter of a 16-bit stack processor from the instruction currently being executed. Jump, conditional jump and call instructions carry a 13-bit target field. The block turns that field into an absolute address, or into a PC-relative one when relative mode is built in and the field's top bit asks for it. For a conditional jump it signals that the flag on top of the data stack is consumed. For a call it supplies the return address to push.

A separate bank-load instruction writes a 4-bit value into a one-shot bank register. The next instruction uses that value as the upper four bits of an absolute target, so a far branch costs two instructions. The register clears itself after one cycle, whatever instruction follows. The PC register, the stacks, the ALU and the memory live outside the block. The block is purely combinational apart from the bank register.

Top module: `btu_top`

## Requirements
- R1: While `rst_n` is low, `next_pc` is 0. After reset the bank register holds 0.
- R2: An absolute jump (`br_kind` = 2'b01, and `tgt_field[12]` = 0 when relative mode is built in) sets `next_pc` to the bank value in bits 15:12, ORed with the zero-extended low 12 field bits. Without relative mode, all 13 field bits are used. `flag_pop` and `ret_push` are 0.
- R3: A conditional jump (`br_kind` = 2'b10) whose `tos_flag` is zero goes to the target, and `flag_pop` is 1.
- R4: A conditional jump whose `tos_flag` is non-zero sets `next_pc` to `cur_pc`+1, and `flag_pop` is still 1.
- R5: A call (`br_kind` = 2'b11) goes to the target, raises `ret_push`, and `ret_addr` equals `cur_pc`+1 modulo 2^16.
- R6: A non-branch (`br_kind` = 2'b00) sets `next_pc` to `cur_pc`+1 modulo 2^16, with `flag_pop` and `ret_push` at 0.
- R7: In a cycle with `bank_load` = 1, `br_kind` is ignored and `next_pc` is `cur_pc`+1. In the following cycle, absolute targets take `bank_value` as bits 15:12.
- R8: The bank register returns to 0 one cycle after a load unless it is loaded again. A second branch therefore sees bank 0.
- R9: With relative mode built in, `tgt_field[12]` = 1 makes the target `cur_pc` plus the sign-extended `tgt_field[11:0]` modulo 2^16. The bank value is not applied.
- R10: Relative offsets reach -2048 (field 12'h800) and +2047 (field 12'h7FF), and wrap around address 0 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 16 | Address of the instruction now executing |
| br_kind | input | 2 | 00 none, 01 jump, 10 conditional jump, 11 call |
| tgt_field | input | 13 | Target field of the branch instruction |
| tos_flag | input | 16 | Top of data stack, tested by conditional jumps |
| bank_load | input | 1 | Current instruction loads the bank register |
| bank_value | input | 4 | Value loaded into the bank register |
| next_pc | output | 16 | Address of the next instruction |
| ret_addr | output | 16 | Return address for a call |
| ret_push | output | 1 | Push `ret_addr` onto the return stack |
| flag_pop | output | 1 | Pop the flag from the data stack |

## Verification
The bench targets the one-shot bank timing. It checks that the bank value is used exactly one instruction after the load and not two. A register that failed to clear would send the second branch far. A register applied in the load cycle would corrupt that cycle's PC increment.

Relative offsets are driven at both extremes and across address 0. This catches a zero-extended offset, which would jump forward instead of back, and a bank wrongly merged into relative targets. Conditional jumps are run with a zero flag and with a flag that has only the top bit set. A design testing only bit 0 would take the second branch. `flag_pop` is also checked on the not-taken path.

// File: rtl/btu_pkg.sv
package btu_pkg;
    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_JMP  = 2'b01,
        BR_CJMP = 2'b10,
        BR_CALL = 2'b11
    } br_kind_e;
endpackage

// File: rtl/btu_bank_reg.sv
module btu_bank_reg #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] value,
    output logic [BANK_W-1:0] bank
);
    typedef struct packed {
        logic [BANK_W-1:0] bank;
    } bank_st_t;

    bank_st_t st_d, st_q;

    // one-shot: whatever is loaded lives for exactly one cycle
    always_comb begin
        st_d.bank = load ? value : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank = st_q.bank;
endmodule

// File: rtl/btu_target_calc.sv
module btu_target_calc #(
    parameter int PC_W    = 16,
    parameter int FIELD_W = 13,
    parameter int BANK_W  = 4,
    parameter bit REL_EN  = 1'b1
) (
    input  logic [PC_W-1:0]    cur_pc,
    input  logic [FIELD_W-1:0] field,
    input  logic [BANK_W-1:0]  bank,
    output logic [PC_W-1:0]    target
);
    localparam int OFF_W = FIELD_W - 1;
    localparam int ABS_W = REL_EN ? FIELD_W - 1 : FIELD_W;
    localparam int LOW_W = PC_W - BANK_W;

    logic [PC_W-1:0] abs_tgt;

    assign abs_tgt = {bank, {LOW_W{1'b0}}} | PC_W'(field[ABS_W-1:0]);

    generate
        if (REL_EN) begin : g_rel
            logic [PC_W-1:0] rel_tgt;
            assign rel_tgt = cur_pc + {{(PC_W-OFF_W){field[OFF_W-1]}}, field[OFF_W-1:0]};
            assign target  = field[FIELD_W-1] ? rel_tgt : abs_tgt;
        end else begin : g_abs
            logic [PC_W-1:0] pc_unused;
            assign pc_unused = cur_pc;
            assign target    = abs_tgt;
        end
    endgenerate
endmodule

// File: rtl/btu_top.sv
module btu_top #(
    parameter int PC_W    = 16,
    parameter int FIELD_W = 13,
    parameter int BANK_W  = 4,
    parameter int FLAG_W  = 16,
    parameter bit REL_EN  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PC_W-1:0]    cur_pc,
    input  logic [1:0]         br_kind,
    input  logic [FIELD_W-1:0] tgt_field,
    input  logic [FLAG_W-1:0]  tos_flag,
    input  logic               bank_load,
    input  logic [BANK_W-1:0]  bank_value,
    output logic [PC_W-1:0]    next_pc,
    output logic [PC_W-1:0]    ret_addr,
    output logic               ret_push,
    output logic               flag_pop
);
    import btu_pkg::*;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            push;
        logic            pop;
    } step_t;

    logic [BANK_W-1:0] bank_q;
    logic [PC_W-1:0]   target;
    logic [PC_W-1:0]   pc_inc;
    step_t             step_d;
    br_kind_e          kind;

    btu_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bank_load),
        .value (bank_value),
        .bank  (bank_q)
    );

    btu_target_calc #(
        .PC_W(PC_W), .FIELD_W(FIELD_W), .BANK_W(BANK_W), .REL_EN(REL_EN)
    ) u_tgt (
        .cur_pc (cur_pc),
        .field  (tgt_field),
        .bank   (bank_q),
        .target (target)
    );

    assign pc_inc = cur_pc + PC_W'(1);
    assign kind   = br_kind_e'(br_kind);

    always_comb begin
        step_d.pc   = pc_inc;
        step_d.push = 1'b0;
        step_d.pop  = 1'b0;
        if (!rst_n) begin
            step_d.pc = '0;
        end else if (!bank_load) begin
            unique case (kind)
                BR_JMP:  step_d.pc = target;
                BR_CJMP: begin
                    step_d.pop = 1'b1;
                    if (tos_flag == '0) step_d.pc = target;
                end
                BR_CALL: begin
                    step_d.pc   = target;
                    step_d.push = 1'b1;
                end
                default: step_d.pc = pc_inc;
            endcase
        end
    end

    assign next_pc  = step_d.pc;
    assign ret_push = step_d.push;
    assign flag_pop = step_d.pop;
    assign ret_addr = pc_inc;
endmodule

module btu_checker #(
    parameter int PC_W   = 16,
    parameter int BANK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   cur_pc,
    input logic [1:0]        br_kind,
    input logic              bank_load,
    input logic [BANK_W-1:0] bank_value,
    input logic [BANK_W-1:0] bank_q,
    input logic [PC_W-1:0]   next_pc,
    input logic [PC_W-1:0]   ret_addr,
    input logic              ret_push,
    input logic              flag_pop
);
    // R1
    reset_pc_zero_chk: assert property (@(posedge clk) !rst_n |-> next_pc == '0);

    // R7
    bank_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_load |=> bank_q == $past(bank_value));

    // R8
    bank_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_load |=> bank_q == '0);

    // R7
    bank_cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_load |-> (next_pc == cur_pc + PC_W'(1)) && !ret_push && !flag_pop);

    // R5
    call_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_push |-> ret_addr == cur_pc + PC_W'(1));

    // R3
    cond_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'b10 && !bank_load) |-> flag_pop && !ret_push);

    // R6
    plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'b00) |-> (next_pc == cur_pc + PC_W'(1)) && !flag_pop && !ret_push);
endmodule

bind btu_top btu_checker #(.PC_W(PC_W), .BANK_W(BANK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .br_kind(br_kind),
    .bank_load(bank_load), .bank_value(bank_value), .bank_q(bank_q),
    .next_pc(next_pc), .ret_addr(ret_addr), .ret_push(ret_push), .flag_pop(flag_pop)
);

// File: tb/tb_btu_top.sv
module tb_btu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cur_pc = '0;
    logic [1:0]  br_kind = 2'b00;
    logic [12:0] tgt_field = '0;
    logic [15:0] tos_flag = '0;
    logic        bank_load = 1'b0;
    logic [3:0]  bank_value = '0;
    logic [15:0] next_pc, ret_addr;
    logic        ret_push, flag_pop;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    btu_top dut (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .br_kind(br_kind),
        .tgt_field(tgt_field), .tos_flag(tos_flag), .bank_load(bank_load),
        .bank_value(bank_value), .next_pc(next_pc), .ret_addr(ret_addr),
        .ret_push(ret_push), .flag_pop(flag_pop)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one instruction after a falling edge, sample before the rising edge
    task automatic step(input logic [15:0] pc, input logic [1:0] k, input logic [12:0] f,
                        input logic [15:0] flag, input logic bl, input logic [3:0] bv);
        @(negedge clk);
        cur_pc = pc; br_kind = k; tgt_field = f; tos_flag = flag;
        bank_load = bl; bank_value = bv;
        #2;
    endtask

    task automatic t_reset;
        step(16'h1234, 2'b01, 13'h0055, 16'h0, 1'b0, 4'h0);
        chk("R1 next_pc in reset", next_pc, 16'h0000);
        @(negedge clk); rst_n = 1'b1;
        step(16'h0010, 2'b01, 13'h0ABC, 16'h0, 1'b0, 4'h0);
        chk("R1 bank zero after reset", next_pc, 16'h0ABC);
    endtask

    task automatic t_plain;
        step(16'h0020, 2'b00, 13'h1FFF, 16'h0, 1'b0, 4'h0);
        chk("R6 increment", next_pc, 16'h0021);
        chk("R6 no pop/push", {14'h0, flag_pop, ret_push}, 16'h0);
        step(16'hFFFF, 2'b00, 13'h0000, 16'h0, 1'b0, 4'h0);
        chk("R6 wrap", next_pc, 16'h0000);
    endtask

    task automatic t_jump;
        step(16'h0300, 2'b01, 13'h0FFF, 16'h0, 1'b0, 4'h0);
        chk("R2 absolute max", next_pc, 16'h0FFF);
        chk("R2 no pop/push", {14'h0, flag_pop, ret_push}, 16'h0);
    endtask

    task automatic t_cond;
        step(16'h0040, 2'b10, 13'h0123, 16'h0000, 1'b0, 4'h0);
        chk("R3 taken", next_pc, 16'h0123);
        chk("R3 pop", {15'h0, flag_pop}, 16'h1);
        step(16'h0040, 2'b10, 13'h0123, 16'h8000, 1'b0, 4'h0);
        chk("R4 not taken", next_pc, 16'h0041);
        chk("R4 pop", {15'h0, flag_pop}, 16'h1);
    endtask

    task automatic t_call;
        step(16'h0077, 2'b11, 13'h0FFF, 16'h0, 1'b0, 4'h0);
        chk("R5 target", next_pc, 16'h0FFF);
        chk("R5 push", {15'h0, ret_push}, 16'h1);
        chk("R5 ret_addr", ret_addr, 16'h0078);
    endtask

    task automatic t_bank;
        step(16'h0100, 2'b01, 13'h0ABC, 16'h0, 1'b1, 4'h5);
        chk("R7 load cycle increments", next_pc, 16'h0101);
        step(16'h0101, 2'b01, 13'h0ABC, 16'h0, 1'b0, 4'h0);
        chk("R7 far jump", next_pc, 16'h5ABC);
        step(16'h5ABC, 2'b01, 13'h0ABC, 16'h0, 1'b0, 4'h0);
        chk("R8 bank cleared", next_pc, 16'h0ABC);
        step(16'h0200, 2'b00, 13'h0, 16'h0, 1'b1, 4'hF);
        step(16'h0201, 2'b11, 13'h0001, 16'h0, 1'b0, 4'h0);
        chk("R7 far call", next_pc, 16'hF001);
        chk("R5 far call ret", ret_addr, 16'h0202);
    endtask

    task automatic t_rel;
        step(16'h1000, 2'b01, 13'h1800, 16'h0, 1'b0, 4'h0);
        chk("R10 min offset", next_pc, 16'h0800);
        step(16'h1000, 2'b01, 13'h17FF, 16'h0, 1'b0, 4'h0);
        chk("R10 max offset", next_pc, 16'h17FF);
        step(16'h0005, 2'b01, 13'h1FF8, 16'h0, 1'b0, 4'h0);
        chk("R10 wrap below zero", next_pc, 16'hFFFD);
        step(16'hFFFF, 2'b11, 13'h1001, 16'h0, 1'b0, 4'h0);
        chk("R10 wrap above top", next_pc, 16'h0000);
        step(16'h2000, 2'b00, 13'h0, 16'h0, 1'b1, 4'h3);
        step(16'h2001, 2'b01, 13'h1004, 16'h0, 1'b0, 4'h0);
        chk("R9 bank not applied", next_pc, 16'h2005);
    endtask

    task automatic run_all;
        t_reset();
        t_plain();
        t_jump();
        t_cond();
        t_call();
        t_bank();
        t_rel();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule